// File: doc/BRIEF.md
# Sector ECC Syndrome Checker and Corrector

This block checks the Hamming code kept beside each 512-byte sector of a flash page against the code computed while that sector was read, and repairs a single flipped data bit in place. On a start pulse it latches both code sets and walks either one sector or, in multi-sector mode, four consecutive sectors of a 2048-byte page. For every sector it forms the 24-bit syndrome, counts its set bits and classifies the sector as clean, correctable or fatal. A correctable sector is repaired through a byte-wide port to an external sector buffer with synchronous reads, using a fixed read-then-write pair of cycles.

The walk ends early at the first fatal sector. At the end a one-cycle done pulse is given, with an overall status, the sector that was last repaired or that failed, and the byte offset and bit index of the last repair. An erased page, whose stored code reads as all ones while the computed code is all zeros, is reported clean.

The controller is a five-state machine. IDLE waits for start. EVAL classifies the current sector and either stays in EVAL for the next sector (clean, more to go), goes to READ (correctable), or goes to FINISH (clean on the last sector, or fatal). READ issues the buffer read and always goes to WRITE. WRITE writes the repaired byte and returns to EVAL when sectors remain, or to FINISH after the last one. FINISH raises done and returns to IDLE.

Top module: `sector_ecc_corrector`

## Requirements
- R1: After reset, busy and done are low and status reads clean (encoding: 0 clean, 1 corrected, 2 uncorrectable).
- R2: A sector whose stored and computed codes are equal is clean and causes no buffer read or write.
- R3: Code layout: for address bit k of the 12-bit bit address {byte[8:0], bit[2:0]}, code bit k is the even parity and code bit 12+k the odd parity. A syndrome (stored XOR computed) with exactly 12 bits set is correctable; the byte offset is syndrome bits [23:15] and the bit index syndrome bits [14:12].
- R4: A correction reads buffer address {sector, byte} in one cycle and, in the next cycle, writes the returned byte with the indicated bit inverted to the same address.
- R5: Any other nonzero syndrome weight, including 1 and 11, is reported uncorrectable.
- R6: A stored code of all ones together with a computed code of all zeros is reported clean.
- R7: In multi-sector mode sectors 0 to 3 are checked in order, sector k using code bits [24k+23:24k] of each code input; in single mode only sector 0 is checked and the other slices have no effect.
- R8: The walk stops at the first uncorrectable sector; err_sector names it and no later sector is read or written.
- R9: The final status is corrected if any sector was repaired and none failed; err_sector, err_byte and err_bit then give the last repair.
- R10: done is a single-cycle pulse after which busy is low, and the status outputs hold their value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check; sampled only when idle |
| multi_sector | input | 1 | 1: check four sectors, 0: check sector 0 only |
| stored_code | input | 96 | Codes read from the spare area, 24 bits per sector |
| calc_code | input | 96 | Codes computed on read, 24 bits per sector |
| buf_rd_en | output | 1 | Sector buffer read request |
| buf_wr_en | output | 1 | Sector buffer write request |
| buf_addr | output | 11 | Buffer byte address {sector, byte} |
| buf_wdata | output | 8 | Repaired byte |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after the read |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle pulse at the end of a check |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| err_sector | output | 2 | Sector of the last repair or of the failure |
| err_byte | output | 9 | Byte offset of the last repair |
| err_bit | output | 3 | Bit index of the last repair |

## Verification
The bench computes codes from its own buffer model, flips data or code bits and checks that repairs restore the buffer exactly; a wrong offset or bit mapping would corrupt a second byte and leave the first one damaged. It drives syndromes of weight 1, 2, 11 and 23 next to the weight-12 case, which a design testing only for a nonzero syndrome or a near-miss count would repair wrongly. It places a repairable sector after a fatal one and errors in sectors 1 to 3 under single mode, where a design that did not stop or that ignored the mode would write the buffer. The erased-page pattern is checked beside a near-erased one, to catch a design that treats any all-ones stored code as clean.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

    typedef enum logic [1:0] {
        RES_CLEAN = 2'd0,
        RES_FIXED = 2'd1,
        RES_FATAL = 2'd2
    } result_t;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_SINGLE = 2'd1,
        CLS_MULTI  = 2'd2
    } class_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_EVAL   = 3'd1,
        ST_READ   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_FINISH = 3'd4
    } fsm_t;

endpackage

// File: rtl/ecc_code_select.sv
module ecc_code_select #(
    parameter int CODE_W  = 24,
    parameter int SECTORS = 4,
    parameter int SEC_W   = 2
) (
    input  logic [SECTORS*CODE_W-1:0] stored_all,
    input  logic [SECTORS*CODE_W-1:0] calc_all,
    input  logic [SEC_W-1:0]          sel,
    output logic [CODE_W-1:0]         stored_one,
    output logic [CODE_W-1:0]         calc_one
);

    logic [CODE_W-1:0] stored_arr [SECTORS];
    logic [CODE_W-1:0] calc_arr   [SECTORS];

    for (genvar g = 0; g < SECTORS; g++) begin : g_slice
        assign stored_arr[g] = stored_all[g*CODE_W +: CODE_W];
        assign calc_arr[g]   = calc_all[g*CODE_W +: CODE_W];
    end

    always_comb begin
        stored_one = '0;
        calc_one   = '0;
        for (int i = 0; i < SECTORS; i++) begin
            if (SEC_W'(i) == sel) begin
                stored_one = stored_arr[i];
                calc_one   = calc_arr[i];
            end
        end
    end

endmodule

// File: rtl/ecc_syndrome_eval.sv
module ecc_syndrome_eval
    import ecc_chk_pkg::*;
#(
    parameter int BYTE_W = 9,
    parameter int BIT_W  = 3
) (
    input  logic [2*(BYTE_W+BIT_W)-1:0] stored,
    input  logic [2*(BYTE_W+BIT_W)-1:0] calc,
    output class_t                      cls,
    output logic [BYTE_W-1:0]           loc_byte,
    output logic [BIT_W-1:0]            loc_bit
);

    localparam int LOC_W  = BYTE_W + BIT_W;
    localparam int CODE_W = 2 * LOC_W;
    localparam int CNT_W  = $clog2(CODE_W + 1);

    logic [CODE_W-1:0] syndrome;
    logic [CNT_W-1:0]  weight;
    logic              erased;
    logic [LOC_W-1:0]  odd_half;

    assign syndrome = stored ^ calc;
    assign erased   = (&stored) && !(|calc);
    assign odd_half = syndrome[CODE_W-1:LOC_W];
    assign loc_byte = odd_half[LOC_W-1:BIT_W];
    assign loc_bit  = odd_half[BIT_W-1:0];

    always_comb begin
        weight = '0;
        for (int i = 0; i < CODE_W; i++) begin
            weight = weight + CNT_W'(syndrome[i]);
        end
    end

    always_comb begin
        if (!(|syndrome) || erased) begin
            cls = CLS_NONE;
        end else if (weight == CNT_W'(LOC_W)) begin
            cls = CLS_SINGLE;
        end else begin
            cls = CLS_MULTI;
        end
    end

endmodule

// File: rtl/sector_ecc_corrector.sv
module sector_ecc_corrector
    import ecc_chk_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int DATA_W       = 8,
    parameter int MAX_SECTORS  = 4,
    localparam int BYTE_W = $clog2(SECTOR_BYTES),
    localparam int BIT_W  = $clog2(DATA_W),
    localparam int LOC_W  = BYTE_W + BIT_W,
    localparam int CODE_W = 2 * LOC_W,
    localparam int SEC_W  = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1,
    localparam int ADDR_W = SEC_W + BYTE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          multi_sector,
    input  logic [MAX_SECTORS*CODE_W-1:0] stored_code,
    input  logic [MAX_SECTORS*CODE_W-1:0] calc_code,
    output logic                          buf_rd_en,
    output logic                          buf_wr_en,
    output logic [ADDR_W-1:0]             buf_addr,
    output logic [DATA_W-1:0]             buf_wdata,
    input  logic [DATA_W-1:0]             buf_rdata,
    output logic                          busy,
    output logic                          done,
    output logic [1:0]                    status,
    output logic [SEC_W-1:0]              err_sector,
    output logic [BYTE_W-1:0]             err_byte,
    output logic [BIT_W-1:0]              err_bit
);

    localparam logic [SEC_W-1:0] LAST_MULTI = SEC_W'(MAX_SECTORS - 1);

    fsm_t                          state_q, state_d;
    logic [MAX_SECTORS*CODE_W-1:0] stored_q, calc_q;
    logic                          multi_q;
    logic [SEC_W-1:0]              sector_q;
    result_t                       result_q;
    logic [SEC_W-1:0]              err_sector_q;
    logic [BYTE_W-1:0]             err_byte_q;
    logic [BIT_W-1:0]              err_bit_q;

    logic [CODE_W-1:0]             cur_stored, cur_calc;
    class_t                        cur_cls;
    logic [BYTE_W-1:0]             cur_byte;
    logic [BIT_W-1:0]              cur_bit;
    logic                          on_last;

    ecc_code_select #(
        .CODE_W  (CODE_W),
        .SECTORS (MAX_SECTORS),
        .SEC_W   (SEC_W)
    ) u_select (
        .stored_all (stored_q),
        .calc_all   (calc_q),
        .sel        (sector_q),
        .stored_one (cur_stored),
        .calc_one   (cur_calc)
    );

    ecc_syndrome_eval #(
        .BYTE_W (BYTE_W),
        .BIT_W  (BIT_W)
    ) u_eval (
        .stored   (cur_stored),
        .calc     (cur_calc),
        .cls      (cur_cls),
        .loc_byte (cur_byte),
        .loc_bit  (cur_bit)
    );

    assign on_last = multi_q ? (sector_q == LAST_MULTI) : 1'b1;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                unique case (cur_cls)
                    CLS_NONE:   state_d = on_last ? ST_FINISH : ST_EVAL;
                    CLS_SINGLE: state_d = ST_READ;
                    default:    state_d = ST_FINISH;
                endcase
            end
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = on_last ? ST_FINISH : ST_EVAL;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q     <= '0;
            calc_q       <= '0;
            multi_q      <= 1'b0;
            sector_q     <= '0;
            result_q     <= RES_CLEAN;
            err_sector_q <= '0;
            err_byte_q   <= '0;
            err_bit_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        stored_q     <= stored_code;
                        calc_q       <= calc_code;
                        multi_q      <= multi_sector;
                        sector_q     <= '0;
                        result_q     <= RES_CLEAN;
                        err_sector_q <= '0;
                        err_byte_q   <= '0;
                        err_bit_q    <= '0;
                    end
                end
                ST_EVAL: begin
                    unique case (cur_cls)
                        CLS_NONE: begin
                            if (!on_last) sector_q <= sector_q + 1'b1;
                        end
                        CLS_SINGLE: begin
                            result_q     <= RES_FIXED;
                            err_sector_q <= sector_q;
                            err_byte_q   <= cur_byte;
                            err_bit_q    <= cur_bit;
                        end
                        default: begin
                            result_q     <= RES_FATAL;
                            err_sector_q <= sector_q;
                        end
                    endcase
                end
                ST_WRITE: begin
                    if (!on_last) sector_q <= sector_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        buf_rd_en  = (state_q == ST_READ);
        buf_wr_en  = (state_q == ST_WRITE);
        buf_addr   = {sector_q, err_byte_q};
        buf_wdata  = buf_rdata ^ (DATA_W'(1) << err_bit_q);
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        status     = result_q;
        err_sector = err_sector_q;
        err_byte   = err_byte_q;
        err_bit    = err_bit_q;
    end

endmodule

// File: rtl/sector_ecc_corrector_chk.sv
module sector_ecc_corrector_chk #(
    parameter int ADDR_W = 11,
    parameter int SEC_W  = 2,
    parameter int BYTE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              buf_rd_en,
    input logic              buf_wr_en,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              busy,
    input logic              done,
    input logic [1:0]        status,
    input logic [SEC_W-1:0]  err_sector,
    input logic [BYTE_W-1:0] err_byte
);

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> buf_wr_en && (buf_addr == $past(buf_addr))); // R4

    AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(buf_rd_en)); // R4

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en)); // R4

    AST_WRITE_AT_LOCATION: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> (buf_addr == {err_sector, err_byte})); // R9

    AST_FATAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2) |-> !buf_wr_en && !buf_rd_en); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R10

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(status) && $stable(err_sector)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !buf_rd_en && !buf_wr_en && !done); // R1

endmodule

bind sector_ecc_corrector sector_ecc_corrector_chk #(
    .ADDR_W (ADDR_W),
    .SEC_W  (SEC_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .buf_rd_en  (buf_rd_en),
    .buf_wr_en  (buf_wr_en),
    .buf_addr   (buf_addr),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .err_sector (err_sector),
    .err_byte   (err_byte)
);

// File: tb/sector_ecc_corrector_test.sv
`timescale 1ns/1ps
module sector_ecc_corrector_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        multi_sector = 1'b0;
    logic [95:0] stored_code = '0;
    logic [95:0] calc_code = '0;
    logic        buf_rd_en, buf_wr_en;
    logic [10:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata = '0;
    logic        busy, done;
    logic [1:0]  status;
    logic [1:0]  err_sector;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;

    logic [7:0]  mem    [2048];
    logic [7:0]  golden [2048];
    int          vectors = 0;
    int          fails = 0;
    int          writes = 0;
    int          cycles = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    sector_ecc_corrector uut (
        .clk (clk), .rst_n (rst_n), .start (start), .multi_sector (multi_sector),
        .stored_code (stored_code), .calc_code (calc_code),
        .buf_rd_en (buf_rd_en), .buf_wr_en (buf_wr_en), .buf_addr (buf_addr),
        .buf_wdata (buf_wdata), .buf_rdata (buf_rdata),
        .busy (busy), .done (done), .status (status),
        .err_sector (err_sector), .err_byte (err_byte), .err_bit (err_bit)
    );

    // Sector buffer model with one-cycle read latency
    always @(posedge clk) begin
        if (buf_rd_en) buf_rdata <= mem[buf_addr];
        if (buf_wr_en) begin
            mem[buf_addr] <= buf_wdata;
            writes <= writes + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors = vectors + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Hamming code of one sector from the bench buffer (layout of R3)
    function automatic logic [23:0] code_of(input int s);
        logic [23:0] c = '0;
        for (int b = 0; b < 512; b++) begin
            for (int i = 0; i < 8; i++) begin
                if (mem[s*512 + b][i]) begin
                    logic [11:0] a = {b[8:0], i[2:0]};
                    for (int k = 0; k < 12; k++) begin
                        if (a[k]) c[12+k] = ~c[12+k];
                        else      c[k]    = ~c[k];
                    end
                end
            end
        end
        return c;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 2048; i++) begin
            mem[i]    = 8'((i * 73 + seed * 11 + (i >> 5)) & 255);
            golden[i] = mem[i];
        end
        for (int s = 0; s < 4; s++) stored_code[s*24 +: 24] = code_of(s);
        calc_code = stored_code;
    endtask

    task automatic flip(input int s, input int b, input int i);
        mem[s*512 + b][i] = ~mem[s*512 + b][i];
        calc_code[s*24 +: 24] = code_of(s);
    endtask

    function automatic int diffs();
        int n = 0;
        for (int i = 0; i < 2048; i++) if (mem[i] !== golden[i]) n++;
        return n;
    endfunction

    task automatic run(input bit multi);
        int t = 0;
        @(negedge clk);
        writes = 0;
        multi_sector = multi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done === 1'b1, "R10 done seen", done, 1);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10 single pulse", {done, busy}, 0);
    endtask

    task automatic t_reset;
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);
        chk(status === 2'd0, "R1 status", status, 0);
    endtask

    task automatic t_clean;
        fill(1);
        run(1'b1);
        chk(status === 2'd0, "R2 clean status", status, 0);
        chk(writes == 0, "R2 no write", writes, 0);
        chk(diffs() == 0, "R2 buffer intact", diffs(), 0);
    endtask

    task automatic t_single;
        fill(2);
        flip(0, 137, 5);
        run(1'b0);
        chk(status === 2'd1, "R3 corrected", status, 1);
        chk(err_byte === 9'd137, "R3 byte", err_byte, 137);
        chk(err_bit === 3'd5, "R3 bit", err_bit, 5);
        chk(writes == 1, "R4 one write", writes, 1);
        chk(diffs() == 0, "R4 buffer repaired", diffs(), 0);
        repeat (3) @(negedge clk);
        chk(status === 2'd1 && err_byte === 9'd137, "R10 status held", status, 1);
    endtask

    task automatic t_multi;
        fill(3);
        flip(1, 300, 6);
        flip(3, 511, 7);
        run(1'b1);
        chk(status === 2'd1, "R9 corrected", status, 1);
        chk(err_sector === 2'd3, "R9 last sector", err_sector, 3);
        chk(err_byte === 9'd511 && err_bit === 3'd7, "R9 last loc", {err_byte, err_bit}, {9'd511, 3'd7});
        chk(writes == 2, "R7 two writes", writes, 2);
        chk(diffs() == 0, "R7 all repaired", diffs(), 0);
    endtask

    task automatic t_weights;
        fill(4);
        stored_code[5] = ~stored_code[5];
        run(1'b0);
        chk(status === 2'd2, "R5 weight 1", status, 2);
        chk(writes == 0, "R5 no write w1", writes, 0);
        fill(4);
        flip(0, 0, 0);
        flip(0, 1, 0);
        run(1'b0);
        chk(status === 2'd2, "R5 weight 2", status, 2);
        fill(4);
        flip(0, 0, 0);
        stored_code[0] = ~stored_code[0];
        run(1'b0);
        chk(status === 2'd2, "R5 weight 11", status, 2);
        chk(writes == 0, "R5 no write w11", writes, 0);
    endtask

    task automatic t_stop;
        fill(5);
        stored_code[24 + 3] = ~stored_code[24 + 3];
        flip(2, 10, 3);
        run(1'b1);
        chk(status === 2'd2, "R8 fatal", status, 2);
        chk(err_sector === 2'd1, "R8 sector", err_sector, 1);
        chk(writes == 0, "R8 no later write", writes, 0);
        chk(diffs() == 1, "R8 later sector untouched", diffs(), 1);
    endtask

    task automatic t_erased;
        fill(6);
        stored_code[23:0] = 24'hFFFFFF;
        calc_code[23:0]   = 24'h000000;
        run(1'b0);
        chk(status === 2'd0, "R6 erased clean", status, 0);
        calc_code[23:0] = 24'h000001;
        run(1'b0);
        chk(status === 2'd2, "R6 near erased fatal", status, 2);
    endtask

    task automatic t_single_mode;
        fill(7);
        flip(2, 44, 1);
        run(1'b0);
        chk(status === 2'd0, "R7 single mode clean", status, 0);
        chk(writes == 0, "R7 single mode no write", writes, 0);
        chk(diffs() == 1, "R7 sector 2 untouched", diffs(), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean();
        t_single();
        t_multi();
        t_weights();
        t_stop();
        t_erased();
        t_single_mode();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule